// File: doc/BRIEF.md
# Grouped Port Interrupt Combiner

This block turns the pins of one or more ports into one interrupt request per port. Software picks which pins of a port take part through a per-pin enable mask. A per-pin polarity mask says whether each chosen pin is active high or active low. Every active, enabled pin adds to a single OR-reduced request for its port, so one interrupt line covers any subset of the port's pins. Ports are instantiated side by side and work independently of each other.

Pin levels are asynchronous, so they pass through a two-flop synchronizer before they are combined. The combined request is registered before it leaves the block. Each port has its own mode select. In level mode the output follows the registered request. In edge mode, a rising edge of the request sets a sticky flag, and the flag stays set until software writes a one to the port's clear strobe. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `grp_port_irq`

## Requirements
- R1: Each port drives its own bit of `irq_o`, and that bit depends only on the pins, masks, mode and clear of the same port.
- R2: A pin whose enable bit is 0 has no effect on its port's request, whatever its level.
- R3: With polarity bit 0 a pin is active when high; with polarity bit 1 it is active when low.
- R4: In level mode (`edge_mode_i` bit = 0) the port request is 1 exactly when at least one enabled pin is active.
- R5: While all enable bits of a port are 0, that port's `irq_o` bit is 0 for any pin levels.
- R6: A pin change is seen on `irq_o` after the third rising clock edge that samples it (two synchronizer flops plus the output register). A change of an enable or polarity bit is seen after the first such edge.
- R7: While reset is asserted, and for the two edges after its release, `irq_o` is all zeros.
- R8: In edge mode (`edge_mode_i` bit = 1) `irq_o` shows a sticky flag. The flag is set on the same edge on which the registered request rises from 0 to 1.
- R9: In edge mode the sticky flag stays set after the request falls. A 1 on the port's `clr_i` bit clears the flag at the next edge.
- R10: When a rising edge of the request and a clear come on the same edge, the flag is set.
- R11: In level mode the sticky flag is held at 0. After a switch to edge mode the flag sets only on a later rising edge of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*PIN_W | Pin levels; port p uses bits [p*PIN_W +: PIN_W] |
| enable_i | input | NUM_PORTS*PIN_W | Per-pin participation mask, 1 = pin takes part |
| polarity_i | input | NUM_PORTS*PIN_W | Per-pin polarity, 1 = active low |
| edge_mode_i | input | NUM_PORTS | Per-port mode, 0 = level, 1 = sticky edge |
| clr_i | input | NUM_PORTS | Per-port write-one-to-clear strobe for the sticky flag |
| irq_o | output | NUM_PORTS | Per-port interrupt request |

## Verification
The embedded assertions check the following on every cycle: the synchronizer delay, the low request under an all-zero mask, sticky set on a rising request, sticky hold without a clear, and sticky clearing in level mode and on a strobe. Polarity inversion, the OR over many pin patterns, port independence and the exact cycle of each change can be shown only by comparing the bench's scenarios against its reference model. The same goes for set winning over a simultaneous clear. Random pins, masks, modes and clears are mixed with directed sequences that time a single pin's latency and collide a clear with a rising edge.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

  // Per-port reporting mode
  typedef enum logic {
    GPI_LEVEL = 1'b0,
    GPI_EDGE  = 1'b1
  } gpi_mode_e;

  // Number of flops in the input synchronizer (fixed by design)
  localparam int unsigned GPI_SYNC_STAGES = 2;

endpackage

// File: rtl/gpi_rst_sync.sv
module gpi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;
  logic meta_d;
  logic hold_d;

  always_comb begin
    meta_d = 1'b1;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] first_q;
  logic [WIDTH-1:0] second_q;
  logic [WIDTH-1:0] first_d;
  logic [WIDTH-1:0] second_d;

  always_comb begin
    first_d  = pin_i;
    second_d = first_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      first_q  <= first_d;
      second_q <= second_d;
    end
  end

  assign sync_o = second_q;

  // Warm-up counter so the delay check looks no further back than reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_o == $past(pin_i, 2)))
    else $error("synchronizer output is not the input two edges earlier");

endmodule

// File: rtl/gpi_port_combine.sv
module gpi_port_combine #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic [WIDTH-1:0] polarity_i,
  output logic             raw_d_o,
  output logic             raw_q_o
);

  logic [WIDTH-1:0] active;
  logic [WIDTH-1:0] contrib;
  logic             raw_d;
  logic             raw_q;

  // Per-pin term: level matched against polarity, gated by the mask
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      assign active[i]  = sync_i[i] ^ polarity_i[i];
      assign contrib[i] = active[i] & enable_i[i];
    end
  endgenerate

  always_comb begin
    raw_d = |contrib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  assign raw_d_o = raw_d;
  assign raw_q_o = raw_q;

  assert_mask_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |=> !raw_q)
    else $error("request set while every enable bit was clear");

endmodule

// File: rtl/gpi_sticky.sv
module gpi_sticky
  import gpi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gpi_mode_e mode_i,
  input  logic      raw_d_i,
  input  logic      raw_q_i,
  input  logic      clr_i,
  output logic      sticky_o
);

  logic sticky_q;
  logic sticky_d;
  logic rise;

  always_comb begin
    rise = raw_d_i & ~raw_q_i;
    if (mode_i != GPI_EDGE)  sticky_d = 1'b0;
    else if (rise)           sticky_d = 1'b1;
    else if (clr_i)          sticky_d = 1'b0;
    else                     sticky_d = sticky_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

  assert_rise_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i == GPI_EDGE) && $rose(raw_q_i)) |-> sticky_q)
    else $error("request rose in edge mode but flag is clear");

  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && mode_i == GPI_EDGE && !clr_i) |=> sticky_q)
    else $error("flag dropped without a clear");

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GPI_EDGE && clr_i && !(raw_d_i && !raw_q_i)) |=> !sticky_q)
    else $error("clear strobe did not clear the flag");

  assert_level_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GPI_LEVEL) |=> !sticky_q)
    else $error("flag set while in level mode");

endmodule

// File: rtl/grp_port_irq.sv
module grp_port_irq
  import gpi_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PIN_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*PIN_W-1:0] pins_i,
  input  logic [NUM_PORTS*PIN_W-1:0] enable_i,
  input  logic [NUM_PORTS*PIN_W-1:0] polarity_i,
  input  logic [NUM_PORTS-1:0]       edge_mode_i,
  input  logic [NUM_PORTS-1:0]       clr_i,
  output logic [NUM_PORTS-1:0]       irq_o
);

  localparam int unsigned TOTAL_W = NUM_PORTS * PIN_W;

  logic                 rst_sync_n;
  logic [TOTAL_W-1:0]   synced;
  logic [NUM_PORTS-1:0] raw_d;
  logic [NUM_PORTS-1:0] raw_q;
  logic [NUM_PORTS-1:0] sticky;

  gpi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      gpi_mode_e mode;
      assign mode = gpi_mode_e'(edge_mode_i[p]);

      gpi_sync #(.WIDTH(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .pin_i  (pins_i[p*PIN_W +: PIN_W]),
        .sync_o (synced[p*PIN_W +: PIN_W])
      );

      gpi_port_combine #(.WIDTH(PIN_W)) u_comb (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .sync_i     (synced[p*PIN_W +: PIN_W]),
        .enable_i   (enable_i[p*PIN_W +: PIN_W]),
        .polarity_i (polarity_i[p*PIN_W +: PIN_W]),
        .raw_d_o    (raw_d[p]),
        .raw_q_o    (raw_q[p])
      );

      gpi_sticky u_stk (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .mode_i   (mode),
        .raw_d_i  (raw_d[p]),
        .raw_q_i  (raw_q[p]),
        .clr_i    (clr_i[p]),
        .sticky_o (sticky[p])
      );

      assign irq_o[p] = (mode == GPI_EDGE) ? sticky[p] : raw_q[p];
    end
  endgenerate

  assert_reset_quiet_R7: assert property (@(posedge clk)
    (!rst_sync_n) |-> (irq_o == '0))
    else $error("request active during reset");

endmodule

// File: tb/grp_port_irq_tb.sv
module grp_port_irq_tb;

  localparam int NP = 2;
  localparam int PW = 8;
  localparam int W  = NP * PW;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  pins;
  logic [W-1:0]  en;
  logic [W-1:0]  pol;
  logic [NP-1:0] em;
  logic [NP-1:0] clr;
  logic [NP-1:0] irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit model_on = 0;
  bit done     = 0;

  grp_port_irq #(.NUM_PORTS(NP), .PIN_W(PW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .enable_i    (en),
    .polarity_i  (pol),
    .edge_mode_i (em),
    .clr_i       (clr),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model built from the requirements
  logic [W-1:0]  m_s1, m_s2;
  logic [NP-1:0] m_raw, m_stk;

  function automatic logic port_req(input logic [W-1:0] lv, input logic [W-1:0] e,
                                    input logic [W-1:0] pl, input int p);
    logic r = 1'b0;
    for (int i = 0; i < PW; i++)
      if (e[p*PW+i] && (lv[p*PW+i] != pl[p*PW+i])) r = 1'b1;
    return r;
  endfunction

  function automatic logic [NP-1:0] expect_irq();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = em[p] ? m_stk[p] : m_raw[p];
    return r;
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_raw = '0; m_stk = '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        logic nr;
        nr = port_req(m_s2, en, pol, p);
        if (!em[p])                 m_stk[p] = 1'b0;
        else if (nr && !m_raw[p])   m_stk[p] = 1'b1;
        else if (clr[p])            m_stk[p] = 1'b0;
        m_raw[p] = nr;
      end
      m_s2 = m_s1;
      m_s1 = pins;
    end
    #2;
    if (model_on && !done) check(em != '0 ? "R8" : "R4", irq, expect_irq());
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic after_edge(); @(posedge clk); #3; endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; pins = '0; en = '0; pol = '0; em = '0; clr = '0;
    repeat (3) tick();
    // R7: quiet during reset
    check("R7", irq, '0);
    rst_n = 1'b1;
    after_edge(); check("R7", irq, '0);
    after_edge(); check("R7", irq, '0);
    repeat (3) tick();
    model_on = 1;

    // R6: single pin latency, port 0 pin 3
    en = '0; en[3] = 1'b1;
    repeat (4) tick();
    pins[3] = 1'b1;
    after_edge(); check("R6", irq, 2'b00);
    after_edge(); check("R6", irq, 2'b00);
    after_edge(); check("R6", irq, 2'b01);
    // R2: disabled pins toggling do not matter; R6 mask change after one edge
    tick(); en[3] = 1'b0;
    after_edge(); check("R6", irq, 2'b00);
    for (int k = 0; k < 8; k++) begin
      tick(); pins[7:0] = 8'(k * 37) | 8'h08; pins[3] = ~pins[3];
      after_edge(); check("R2", irq, 2'b00);
    end
    // R3: polarity 1 makes a low pin active; R1 port 1 only
    tick(); pins = '0; en = '0; en[PW+2] = 1'b1; pol[PW+2] = 1'b1;
    repeat (4) after_edge();
    check("R3", irq, 2'b10);
    check("R1", irq[0], 1'b0);
    tick(); pins[PW+2] = 1'b1;
    repeat (3) after_edge();
    check("R3", irq, 2'b00);

    // R5: all masks clear, random pins
    tick(); en = '0;
    for (int k = 0; k < 20; k++) begin
      tick(); pins = W'($urandom); pol = W'($urandom);
      after_edge(); if (k > 1) check("R5", irq, 2'b00);
    end

    // R8/R9: edge mode on port 0
    tick(); pins = '0; pol = '0; en = '0; en[1] = 1'b1; em = 2'b01;
    repeat (4) tick();
    pins[1] = 1'b1;
    repeat (3) after_edge();
    check("R8", irq[0], 1'b1);
    tick(); pins[1] = 1'b0;
    repeat (5) after_edge();
    check("R9", irq[0], 1'b1);
    tick(); clr[0] = 1'b1;
    after_edge(); check("R9", irq[0], 1'b0);
    tick(); clr[0] = 1'b0;

    // R10: rise and clear on the same edge (driven by the mask)
    tick(); pins[1] = 1'b1; en[1] = 1'b0;
    repeat (4) tick();
    en[1] = 1'b1; clr[0] = 1'b1;
    after_edge(); check("R10", irq[0], 1'b1);
    tick(); clr[0] = 1'b0;

    // R11: level mode holds flag low; switch with request already high
    tick(); em[0] = 1'b0;
    after_edge(); after_edge();
    tick(); em[0] = 1'b1;
    after_edge(); check("R11", irq[0], 1'b0);
    tick(); en[1] = 1'b0;
    after_edge();
    tick(); en[1] = 1'b1;
    after_edge(); check("R11", irq[0], 1'b1);

    // Random mix against the model
    for (int k = 0; k < 3000; k++) begin
      tick();
      pins = W'($urandom);
      if ($urandom_range(0, 7) == 0) en  = W'($urandom) & W'($urandom);
      if ($urandom_range(0, 7) == 0) pol = W'($urandom);
      if ($urandom_range(0, 31) == 0) em = NP'($urandom);
      clr = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
    end
    tick(); clr = '0;
    after_edge();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule